// File: doc/BRIEF.md
# Serial Debug Access Chain

The block is a row of single-bit cells that together shadow one word of a register bus for a debug path. A test controller moves bits through the row serially, one position per pair of shift strobes. It can also copy the whole bus word into the row in one step, or put the row's contents onto the bus in one step. Each cell keeps its bit in inverted form. A word captured from the bus therefore sits in the row as its complement and goes back onto the bus in true form. A word shifted in serially reaches the bus as its complement.

All strobes are synchronous enables, sampled on the rising edge of one system clock. The bus has separate value and drive-enable signals and is never a real tri-state net. A guard watches for illegal strobe combinations. It raises a one-cycle pulse and a flag that stays set until reset.

Top module: `dbg_chain`

## Requirements
- R1: On synchronous reset every stored bit, every serial output, `scan_out`, `err_pulse` and `err_sticky` are 0 after the next rising edge.
- R2: On an edge where `shift_a` is high and `cap_rd` is low, cell i stores the serial output of cell i-1. Cell 0 stores `scan_in`.
- R3: On an edge where `shift_b` is high, each cell's serial output takes that cell's stored bit. `scan_out` is the serial output of cell N-1 and changes only on such an edge.
- R4: One `shift_a` edge followed by one `shift_b` edge moves the row by exactly one position. After N such pairs, cell i holds the bit fed as number N-1-i.
- R5: On an edge where `cap_rd` is high, cell i stores the complement of `bus_in[i]`.
- R6: While `drv_wr` is high, `bus_oe` is all ones and `bus_out[i]` is the complement of cell i's stored bit. While `drv_wr` is low, `bus_oe` and `bus_out` are all zeros.
- R7: When `cap_rd` and `shift_a` are high on the same edge, the bus capture wins and the serial input is ignored.
- R8: `cap_rd` together with `shift_a` is a conflict.
- R9: `cap_rd` together with `drv_wr` is a conflict.
- R10: On the edge after a conflict cycle, `err_pulse` is high for exactly one cycle and `err_sticky` is set. `err_sticky` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_a | input | 1 | First shift strobe: cells load their serial input |
| shift_b | input | 1 | Second shift strobe: cells update their serial output |
| cap_rd | input | 1 | Parallel capture of the bus (stored inverted) |
| drv_wr | input | 1 | Parallel drive of the row onto the bus |
| scan_in | input | 1 | Serial input to cell 0 |
| scan_out | output | 1 | Serial output of cell N-1 |
| bus_in | input | N | Bus value seen by the cells |
| bus_out | output | N | Value the cells drive on the bus |
| bus_oe | output | N | Per-bit drive enable |
| err_pulse | output | 1 | One-cycle conflict indication |
| err_sticky | output | 1 | Conflict flag held until reset |

## Verification
The bound checker tests these properties on every cycle:
- the guard's pulse and sticky flag follow each conflict;
- `scan_out` holds steady without `shift_b`;
- the bus enable is all-or-nothing;
- a capture followed at once by a write returns the captured word unchanged.

Only the bench scenarios can show the following:
- that N shift pairs place a serial pattern in the intended bit order;
- that a captured word shifts out complemented;
- that a capture overrides a coincident shift.

The bench checks these by comparison with its behavioural model.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
  // strobe bundle shared by every cell
  typedef struct packed {
    logic load_ser;  // first shift strobe
    logic upd_out;   // second shift strobe
    logic cap;       // bus capture
    logic drv;       // bus drive
  } strobe_t;
endpackage

// File: rtl/dbg_chain_cell.sv
module dbg_chain_cell
  import dbg_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  logic    ser_in,
  input  logic    bus_bit,
  output logic    store_q,
  output logic    ser_q
);
  // capture has priority over the serial load
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= 1'b0;
    end else if (stb.cap) begin
      store_q <= ~bus_bit;
    end else if (stb.load_ser) begin
      store_q <= ser_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
    end else if (stb.upd_out) begin
      ser_q <= store_q;
    end
  end
endmodule

// File: rtl/dbg_chain_guard.sv
module dbg_chain_guard
  import dbg_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  output logic    err_pulse,
  output logic    err_sticky
);
  logic clash;
  assign clash = stb.cap & (stb.load_ser | stb.drv);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse  <= clash;
      err_sticky <= err_sticky | clash;
    end
  end
endmodule

// File: rtl/dbg_chain.sv
module dbg_chain
  import dbg_chain_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_a,
  input  logic         shift_b,
  input  logic         cap_rd,
  input  logic         drv_wr,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [N-1:0] bus_in,
  output logic [N-1:0] bus_out,
  output logic [N-1:0] bus_oe,
  output logic         err_pulse,
  output logic         err_sticky
);
  localparam int LAST = N - 1;

  strobe_t      stb;
  logic [N-1:0] store_v;
  logic [N-1:0] ser_v;

  assign stb = '{load_ser: shift_a, upd_out: shift_b, cap: cap_rd, drv: drv_wr};

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic feed;
    if (i == 0) begin : g_head
      assign feed = scan_in;
    end else begin : g_link
      assign feed = ser_v[i-1];
    end

    dbg_chain_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .stb     (stb),
      .ser_in  (feed),
      .bus_bit (bus_in[i]),
      .store_q (store_v[i]),
      .ser_q   (ser_v[i])
    );

    assign bus_oe[i]  = drv_wr;
    assign bus_out[i] = drv_wr & ~store_v[i];
  end

  assign scan_out = ser_v[LAST];

  dbg_chain_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky)
  );
endmodule

// File: rtl/dbg_chain_checker.sv
module dbg_chain_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_a,
  input logic         shift_b,
  input logic         cap_rd,
  input logic         drv_wr,
  input logic         scan_out,
  input logic [N-1:0] bus_in,
  input logic [N-1:0] bus_out,
  input logic [N-1:0] bus_oe,
  input logic         err_pulse,
  input logic         err_sticky
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!scan_out && !err_pulse && !err_sticky));

  assert_out_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_b |=> $stable(scan_out));

  assert_capture_roundtrip_R5: assert property (@(posedge clk) disable iff (rst)
    cap_rd |=> (!drv_wr || bus_out == $past(bus_in)));

  assert_enable_all_or_none_R6: assert property (@(posedge clk) disable iff (rst)
    drv_wr ? (&bus_oe) : (bus_oe == '0 && bus_out == '0));

  assert_rd_shift_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_rd && shift_a) |=> (err_pulse && err_sticky));

  assert_rd_wr_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cap_rd && drv_wr) |=> (err_pulse && err_sticky));

  assert_no_false_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !(cap_rd && (shift_a || drv_wr)) |=> !err_pulse);

  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
endmodule

bind dbg_chain dbg_chain_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_a    (shift_a),
  .shift_b    (shift_b),
  .cap_rd     (cap_rd),
  .drv_wr     (drv_wr),
  .scan_out   (scan_out),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky)
);

// File: tb/dbg_chain_bench.sv
module dbg_chain_bench;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_a = 1'b0, shift_b = 1'b0, cap_rd = 1'b0, drv_wr = 1'b0, scan_in = 1'b0;
  logic [N-1:0] bus_in = '0;
  logic         scan_out, err_pulse, err_sticky;
  logic [N-1:0] bus_out, bus_oe;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_chain #(.N(N)) u_dbg_chain (
    .clk(clk), .rst(rst), .shift_a(shift_a), .shift_b(shift_b),
    .cap_rd(cap_rd), .drv_wr(drv_wr), .scan_in(scan_in), .scan_out(scan_out),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  // behavioural reference: held and presented bits as vectors
  logic [N-1:0] m_held = '0, m_shown = '0;
  logic         m_pulse = 1'b0, m_flag = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_held <= '0; m_shown <= '0; m_pulse <= 1'b0; m_flag <= 1'b0;
    end else begin
      if (cap_rd)       m_held <= ~bus_in;
      else if (shift_a) m_held <= {m_shown[N-2:0], scan_in};
      if (shift_b)      m_shown <= m_held;
      m_pulse <= cap_rd && (shift_a || drv_wr);
      m_flag  <= m_flag || (cap_rd && (shift_a || drv_wr));
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // apply strobes for one cycle, then compare every output against the model
  task automatic cyc(logic r, logic a, logic b, logic rd, logic wr, logic si, logic [N-1:0] bv);
    rst = r; shift_a = a; shift_b = b; cap_rd = rd; drv_wr = wr; scan_in = si; bus_in = bv;
    @(negedge clk);
    check("R3 scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_shown[N-1]});
    check("R6 bus_oe", bus_oe, drv_wr ? '1 : '0);
    check("R6 bus_out", bus_out, drv_wr ? ~m_held : '0);
    check("R10 err_pulse", {{(N-1){1'b0}}, err_pulse}, {{(N-1){1'b0}}, m_pulse});
    check("R10 err_sticky", {{(N-1){1'b0}}, err_sticky}, {{(N-1){1'b0}}, m_flag});
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, '0);
  endtask

  // N A/B pairs feeding pat[N-1] first so that cell i ends with pat[i]
  task automatic load_serial(logic [N-1:0] pat);
    for (int k = 0; k < N; k++) begin
      cyc(0, 1, 0, 0, 0, pat[N-1-k], '0);
      cyc(0, 0, 1, 0, 0, 0, '0);
    end
  endtask

  task automatic write_check(string req, logic [N-1:0] exp);
    cyc(0, 0, 0, 0, 1, 0, '0);
    check(req, bus_out, exp);
    idle();
  endtask

  task automatic read_then_unload(logic [N-1:0] v);
    logic [N-1:0] got;
    cyc(0, 0, 0, 1, 0, 0, v);
    idle();
    for (int k = 0; k < N; k++) begin
      cyc(0, 0, 1, 0, 0, 0, '0);
      got[N-1-k] = scan_out;
      cyc(0, 1, 0, 0, 0, 0, '0);
    end
    check("R4 R5 shift-out of capture", got, ~v);
  endtask

  initial begin
    logic [N-1:0] pats [4];
    pats[0] = '1;
    pats[1] = {(N/2){2'b10}};
    pats[2] = {$urandom, $urandom};
    pats[3] = {{(N-1){1'b0}}, 1'b1};

    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(1, 1, 1, 1, 1, 1, '1);
    cyc(0, 0, 0, 0, 0, 0, '0);
    check("R1 reset word", bus_out | {{(N-1){1'b0}}, scan_out}, '0);
    write_check("R1 reset held bits", '1);

    // R2: one serial load of a 1 into cell 0
    cyc(0, 1, 0, 0, 0, 1, '0);
    write_check("R2 cell0 load", {{(N-1){1'b1}}, 1'b0});

    for (int p = 0; p < 4; p++) begin
      load_serial(pats[p]);
      write_check("R4 serial load then write", ~pats[p]);
    end

    for (int p = 0; p < 3; p++) begin
      read_then_unload(pats[p] ^ {N{1'b1}} ^ {$urandom, $urandom});
    end

    // R5: capture then write returns the captured word
    cyc(0, 0, 0, 1, 0, 0, 32'hA5C3_0F96);
    write_check("R5 capture roundtrip", 32'hA5C3_0F96);

    // R7/R8: capture beats coincident serial load, and raises the flag
    cyc(0, 1, 0, 1, 0, 1, 32'h1234_5678);
    check("R8 pulse", {{(N-1){1'b0}}, err_pulse}, {{(N-1){1'b0}}, 1'b1});
    write_check("R7 capture priority", 32'h1234_5678);
    check("R10 sticky holds", {{(N-1){1'b0}}, err_sticky}, {{(N-1){1'b0}}, 1'b1});
    check("R10 pulse single", {{(N-1){1'b0}}, err_pulse}, '0);

    cyc(1, 0, 0, 0, 0, 0, '0);
    idle();
    check("R1 sticky cleared", {{(N-1){1'b0}}, err_sticky}, '0);

    // R9: capture together with write
    cyc(0, 0, 0, 1, 1, 0, 32'hFFFF_0000);
    check("R9 pulse", {{(N-1){1'b0}}, err_pulse}, {{(N-1){1'b0}}, 1'b1});
    idle();
    check("R9 sticky", {{(N-1){1'b0}}, err_sticky}, {{(N-1){1'b0}}, 1'b1});

    // simultaneous A and B shifting across a pattern
    for (int k = 0; k < 8; k++) cyc(0, 1, 1, 0, 0, k[0], '0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule